// File: doc/BRIEF.md
# Lane-to-Serial Ping-Pong Sample Store

This block gathers a frame of compressed complex samples that arrive on 16 parallel lanes and turns them into one serial sample stream. Lane words arrive on a slow strobe. Each accepted word is shifted out one sample per fast-clock cycle, so the serial rate is 16 times the lane rate. Every serial sample is also written into the write bank of a pair of sample memories. The real parts and the imaginary parts are kept in separate memories.

A frame is 10 lane words, which is 160 samples. When its last sample has been written, the banks swap. The frame that has just been completed becomes readable, and the next frame fills the other bank. A downstream inner-product engine reads chosen sample addresses as often as it needs, at a rate of its own. That rate is nominally 128 reads in the time of 160 writes, but the block does not enforce it. Reads only ever see the most recently completed frame. All timing is derived from a single fast clock: the lane strobe and the read requests are enables on that clock.

Top module: `lane_pingpong_store`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `ser_valid`, `frame_ready` and `rd_valid` are 0 and `wr_bank` is 0.
- R2: A `lane_stb` is accepted when the serializer is idle or is showing its last pending sample. The 16 lanes then appear on `ser_re`/`ser_im` with `ser_valid` high, lane 0 first and lane 15 last, one per cycle. The first sample appears in the cycle after the strobe edge. Lane k occupies bits [16k+15:16k] of `lane_re`/`lane_im`.
- R3: A `lane_stb` that arrives while two or more samples are still pending is ignored. Its lane data never appears on the serial output or in the store.
- R4: Within a frame, the serial sample taken from lane k of segment s (the s-th accepted strobe of the frame) is stored at address 16*s + k. Frame addresses therefore run 0 to 159 in serial order.
- R5: In the cycle after the 160th sample of a frame is written, `frame_ready` is high for exactly one cycle and `wr_bank` has inverted. At no other time does `wr_bank` change.
- R6: A read accepted at a clock edge sets `rd_valid` in the following cycle. `rd_re` and `rd_im` then carry the real and imaginary parts stored at `rd_addr` in the most recently completed frame.
- R7: Reads never target the bank being written. While a new frame is being written, and for a read issued on the very edge that completes a frame, the data returned comes from the previously completed frame.
- R8: Until a first frame has been completed, `rd_en` is ignored and `rd_valid` stays 0.
- R9: A read with `rd_addr` of 160 or more is ignored and `rd_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast (serial-rate) clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_stb | input | 1 | Slow-rate strobe: a new lane word is present |
| lane_re | input | 256 | Real parts, 16 lanes of 16 bits, lane k in bits [16k+15:16k] |
| lane_im | input | 256 | Imaginary parts, same lane layout |
| ser_valid | output | 1 | Serial sample present |
| ser_re | output | 16 | Serial sample, real part |
| ser_im | output | 16 | Serial sample, imaginary part |
| wr_bank | output | 1 | Bank currently being written |
| frame_ready | output | 1 | One-cycle pulse when a frame is complete and the banks swap |
| rd_en | input | 1 | Read request |
| rd_addr | input | 8 | Read address within the frame (0 to 159) |
| rd_valid | output | 1 | Read data valid (one cycle after the request) |
| rd_re | output | 16 | Read data, real part |
| rd_im | output | 16 | Read data, imaginary part |

## Verification
Assertions check the following on every cycle:
- the serializer's load and drop rules and its pending count bound;
- that the write index stays inside the frame;
- that the bank pointer moves only together with the frame-ready pulse;
- that at most one bank is written and no bank is written and read in the same cycle;
- that out-of-range reads and reads before the first frame never raise `rd_valid`.

Some behaviour is visible only through the bench's scenarios: the lane order on the serial output, the address mapping, and the returned data values. The bench compares these against a bench-side model of both banks. The scenarios include back-to-back strobes, gaps, a strobe dropped mid-word, reads on the swap edge, and a full address sweep.

// File: rtl/lpp_pkg.sv
package lpp_pkg;

    localparam int SAMPLE_W   = 16;
    localparam int LANES_DEF  = 16;
    localparam int SEGS_DEF   = 10;

    typedef struct packed {
        logic signed [SAMPLE_W-1:0] re;
        logic signed [SAMPLE_W-1:0] im;
    } cplx_t;

    typedef enum logic {
        BANK_A = 1'b0,
        BANK_B = 1'b1
    } bank_t;

    function automatic bank_t other_bank(input bank_t b);
        return (b == BANK_A) ? BANK_B : BANK_A;
    endfunction

endpackage

// File: rtl/lpp_lane_serializer.sv
module lpp_lane_serializer
    import lpp_pkg::*;
#(
    parameter int LANES = LANES_DEF,
    localparam int CW   = $clog2(LANES + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    stb,
    input  cplx_t [LANES-1:0]       lanes_in,
    output logic                    ser_valid,
    output cplx_t                   ser_sample
);

    localparam logic [CW-1:0] FULL = CW'(LANES);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0]     pending;
    cplx_t [LANES-1:0] shreg;
    logic              accept;

    // new word may be taken when idle or while the last sample is on the output
    assign accept = stb && (pending <= ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
            shreg   <= '0;
        end else if (accept) begin
            pending <= FULL;
            shreg   <= lanes_in;
        end else if (pending != '0) begin
            pending <= pending - ONE;
            for (int i = 0; i < LANES - 1; i++) begin
                shreg[i] <= shreg[i+1];
            end
            shreg[LANES-1] <= '0;
        end
    end

    assign ser_valid  = (pending != '0);
    assign ser_sample = shreg[0];

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        accept |=> (ser_valid && pending == FULL));

    assert_drop_busy_R3: assert property (@(posedge clk) disable iff (rst)
        (stb && pending > ONE) |=> (pending == $past(pending) - ONE));

    assert_pending_bound_R2: assert property (@(posedge clk) disable iff (rst)
        pending <= FULL);

endmodule

// File: rtl/lpp_bank_ctrl.sv
module lpp_bank_ctrl
    import lpp_pkg::*;
#(
    parameter int FRAME = LANES_DEF * SEGS_DEF,
    localparam int AW   = $clog2(FRAME)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_valid,
    output logic [AW-1:0]  wr_addr,
    output bank_t          wr_bank,
    output logic           frame_ready,
    output logic           have_frame
);

    localparam logic [AW-1:0] LAST = AW'(FRAME - 1);

    logic frame_done;

    assign frame_done = wr_valid && (wr_addr == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_addr     <= '0;
            wr_bank     <= BANK_A;
            frame_ready <= 1'b0;
            have_frame  <= 1'b0;
        end else begin
            frame_ready <= frame_done;
            if (frame_done) begin
                wr_addr    <= '0;
                wr_bank    <= other_bank(wr_bank);
                have_frame <= 1'b1;
            end else if (wr_valid) begin
                wr_addr <= wr_addr + AW'(1);
            end
        end
    end

    assert_addr_in_frame_R4: assert property (@(posedge clk) disable iff (rst)
        wr_addr <= LAST);

    assert_swap_on_ready_R5: assert property (@(posedge clk) disable iff (rst)
        frame_ready |-> (wr_bank != $past(wr_bank)));

    assert_bank_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !frame_ready |-> $stable(wr_bank));

    assert_ready_source_R5: assert property (@(posedge clk) disable iff (rst)
        frame_ready |-> ($past(wr_valid) && $past(wr_addr) == LAST));

endmodule

// File: rtl/lpp_sample_ram.sv
module lpp_sample_ram #(
    parameter int DEPTH = 160,
    parameter int DW    = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [AW-1:0]  waddr,
    input  logic [DW-1:0]  wdata,
    input  logic           re,
    input  logic [AW-1:0]  raddr,
    output logic [DW-1:0]  rdata
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= mem[raddr];
        end
    end

    assert_waddr_range_R4: assert property (@(posedge clk) disable iff (rst)
        we |-> (waddr <= LAST));

    assert_raddr_range_R9: assert property (@(posedge clk) disable iff (rst)
        re |-> (raddr <= LAST));

endmodule

// File: rtl/lane_pingpong_store.sv
module lane_pingpong_store
    import lpp_pkg::*;
#(
    parameter int LANES = LANES_DEF,
    parameter int SEGS  = SEGS_DEF,
    localparam int W     = SAMPLE_W,
    localparam int FRAME = LANES * SEGS,
    localparam int AW    = $clog2(FRAME)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 lane_stb,
    input  logic [LANES*W-1:0]   lane_re,
    input  logic [LANES*W-1:0]   lane_im,
    output logic                 ser_valid,
    output logic [W-1:0]         ser_re,
    output logic [W-1:0]         ser_im,
    output logic                 wr_bank,
    output logic                 frame_ready,
    input  logic                 rd_en,
    input  logic [AW-1:0]        rd_addr,
    output logic                 rd_valid,
    output logic [W-1:0]         rd_re,
    output logic [W-1:0]         rd_im
);

    localparam logic [AW-1:0] LAST_ADDR = AW'(FRAME - 1);

    cplx_t [LANES-1:0] lanes;
    cplx_t             ser_s;
    logic              ser_v;
    logic [AW-1:0]     wr_addr_i;
    bank_t             wr_bank_i;
    bank_t             rd_bank;
    logic              have_frame;
    logic              rd_ok;
    logic [1:0]        we_b;
    logic [1:0]        re_b;
    logic [W-1:0]      bank_re [2];
    logic [W-1:0]      bank_im [2];
    logic              rd_valid_q;
    logic              rd_sel_q;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lanes[k].re = lane_re[k*W +: W];
        assign lanes[k].im = lane_im[k*W +: W];
    end

    lpp_lane_serializer #(.LANES(LANES)) u_ser (
        .clk        (clk),
        .rst        (rst),
        .stb        (lane_stb),
        .lanes_in   (lanes),
        .ser_valid  (ser_v),
        .ser_sample (ser_s)
    );

    lpp_bank_ctrl #(.FRAME(FRAME)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .wr_valid    (ser_v),
        .wr_addr     (wr_addr_i),
        .wr_bank     (wr_bank_i),
        .frame_ready (frame_ready),
        .have_frame  (have_frame)
    );

    // reads always go to the bank not currently being filled
    assign rd_bank = other_bank(wr_bank_i);
    assign rd_ok   = rd_en && have_frame && (rd_addr <= LAST_ADDR);

    for (genvar b = 0; b < 2; b++) begin : g_bank
        assign we_b[b] = ser_v && (wr_bank_i == bank_t'(b));
        assign re_b[b] = rd_ok && (rd_bank == bank_t'(b));

        lpp_sample_ram #(.DEPTH(FRAME), .DW(W)) u_mem_re (
            .clk   (clk),
            .rst   (rst),
            .we    (we_b[b]),
            .waddr (wr_addr_i),
            .wdata (ser_s.re),
            .re    (re_b[b]),
            .raddr (rd_addr),
            .rdata (bank_re[b])
        );

        lpp_sample_ram #(.DEPTH(FRAME), .DW(W)) u_mem_im (
            .clk   (clk),
            .rst   (rst),
            .we    (we_b[b]),
            .waddr (wr_addr_i),
            .wdata (ser_s.im),
            .re    (re_b[b]),
            .raddr (rd_addr),
            .rdata (bank_im[b])
        );

        assert_no_bank_conflict_R7: assert property (@(posedge clk) disable iff (rst)
            !(we_b[b] && re_b[b]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_q <= 1'b0;
            rd_sel_q   <= 1'b0;
        end else begin
            rd_valid_q <= rd_ok;
            if (rd_ok) begin
                rd_sel_q <= logic'(rd_bank);
            end
        end
    end

    assign ser_valid = ser_v;
    assign ser_re    = ser_s.re;
    assign ser_im    = ser_s.im;
    assign wr_bank   = logic'(wr_bank_i);
    assign rd_valid  = rd_valid_q;
    assign rd_re     = rd_valid_q ? bank_re[rd_sel_q] : '0;
    assign rd_im     = rd_valid_q ? bank_im[rd_sel_q] : '0;

    assert_one_writer_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(we_b));

    assert_read_other_bank_R7: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (rd_sel_q != $past(logic'(wr_bank_i))));

    assert_range_R9: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ($past(rd_addr) <= LAST_ADDR));

    assert_empty_R8: assert property (@(posedge clk) disable iff (rst)
        !have_frame |=> !rd_valid);

endmodule

// File: tb/lane_pingpong_store_tb_top.sv
module lane_pingpong_store_tb_top;

    localparam int LN = 16;
    localparam int SG = 10;
    localparam int FR = LN * SG;
    localparam int W  = 16;

    logic             clk = 1'b0;
    logic             rst;
    logic             lane_stb;
    logic [LN*W-1:0]  lane_re;
    logic [LN*W-1:0]  lane_im;
    logic             ser_valid;
    logic [W-1:0]     ser_re;
    logic [W-1:0]     ser_im;
    logic             wr_bank;
    logic             frame_ready;
    logic             rd_en;
    logic [7:0]       rd_addr;
    logic             rd_valid;
    logic [W-1:0]     rd_re;
    logic [W-1:0]     rd_im;

    always #5 clk = ~clk;

    lane_pingpong_store dut_i (
        .clk(clk), .rst(rst), .lane_stb(lane_stb), .lane_re(lane_re), .lane_im(lane_im),
        .ser_valid(ser_valid), .ser_re(ser_re), .ser_im(ser_im), .wr_bank(wr_bank),
        .frame_ready(frame_ready), .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid),
        .rd_re(rd_re), .rd_im(rd_im)
    );

    int checks = 0;
    int errors = 0;

    // bench model
    logic [31:0] q [$];
    logic [31:0] mdl [0:1][0:FR-1];
    int          widx = 0;
    logic        wbank = 1'b0;
    logic        has_frame = 1'b0;
    logic        exp_fr = 1'b0;
    logic        exp_rv = 1'b0;
    logic [31:0] exp_rd = '0;
    string       exp_rtag = "R8";
    string       ser_tag = "R2";
    bit          sweep = 1'b0;

    task automatic chk(input string tag, input bit ok, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // one cycle: check outputs of the previous edge, then drive the next one
    task automatic tick(input bit stb, input bit rd, input logic [7:0] addr);
        logic [31:0] cur;
        bit          popped;
        @(negedge clk);
        popped = 1'b0;
        cur    = '0;
        if (q.size() > 0) begin
            chk(ser_tag, ser_valid && ({ser_re, ser_im} == q[0]), {31'd0, ser_valid, ser_re, ser_im}, {32'd1, q[0]});
            cur    = q.pop_front();
            popped = 1'b1;
        end else begin
            chk(ser_tag, !ser_valid, {63'd0, ser_valid}, 64'd0);
        end
        chk("R5", frame_ready == exp_fr && wr_bank == wbank, {62'd0, frame_ready, wr_bank}, {62'd0, exp_fr, wbank});
        if (exp_rv)
            chk(exp_rtag, rd_valid && {rd_re, rd_im} == exp_rd, {31'd0, rd_valid, rd_re, rd_im}, {32'd1, exp_rd});
        else
            chk(exp_rtag, !rd_valid, {63'd0, rd_valid}, 64'd0);

        // drive lane word
        lane_stb = stb;
        for (int k = 0; k < LN; k++) begin
            lane_re[k*W +: W] = W'($urandom);
            lane_im[k*W +: W] = W'($urandom);
        end
        if (stb) begin
            if (q.size() == 0) begin
                for (int k = 0; k < LN; k++) q.push_back({lane_re[k*W +: W], lane_im[k*W +: W]});
                ser_tag = "R2";
            end else begin
                ser_tag = "R3";
            end
        end

        // drive read, expected from the pre-edge bank state
        rd_en   = rd;
        rd_addr = addr;
        exp_rv  = rd && has_frame && (addr < FR);
        exp_rd  = (addr < FR) ? mdl[~wbank][addr] : '0;
        if (!has_frame)                         exp_rtag = "R8";
        else if (addr >= FR)                    exp_rtag = "R9";
        else if (sweep)                         exp_rtag = "R4";
        else if (widx != 0 || popped)           exp_rtag = "R7";
        else                                    exp_rtag = "R6";

        // model the write of the sample shown in this cycle
        exp_fr = 1'b0;
        if (popped) begin
            mdl[wbank][widx] = cur;
            widx++;
            if (widx == FR) begin
                widx      = 0;
                wbank     = ~wbank;
                has_frame = 1'b1;
                exp_fr    = 1'b1;
            end
        end
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; lane_stb = 1'b0; lane_re = '0; lane_im = '0; rd_en = 1'b0; rd_addr = '0;
        repeat (3) @(negedge clk);
        chk("R1", !ser_valid && !frame_ready && !rd_valid && !wr_bank,
            {60'd0, ser_valid, frame_ready, rd_valid, wr_bank}, 64'd0);
        rst = 1'b0;

        // reads before any frame exists
        for (int i = 0; i < 12; i++) tick(1'b0, 1'b1, 8'($urandom_range(0, 175)));

        // four frames: back-to-back, with a dropped strobe, with gaps
        for (int f = 0; f < 4; f++) begin
            for (int s = 0; s < SG; s++) begin
                int gap;
                gap = (f == 2) ? int'($urandom_range(0, 3)) : 0;
                tick(1'b1, 1'b1, 8'($urandom_range(0, 175)));
                for (int c = 0; c < 15 + gap; c++) begin
                    tick((f == 1 && s == 3 && c == 6), 1'b1, 8'($urandom_range(0, 175)));
                end
            end
        end

        // drain, then sweep every address of the last completed frame
        for (int i = 0; i < 20; i++) tick(1'b0, 1'b0, 8'd0);
        sweep = 1'b1;
        for (int i = 0; i < FR; i++) tick(1'b0, 1'b1, 8'(i));
        tick(1'b0, 1'b0, 8'd0);
        sweep = 1'b0;
        tick(1'b0, 1'b1, 8'd160);
        tick(1'b0, 1'b1, 8'd255);
        tick(1'b0, 1'b0, 8'd0);

        finish_run();
    end

endmodule